// File: doc/BRIEF.md
# Information Tuple Chain Walker

This block traverses a linked list of variable-length information records ("tuples") held in a byte-addressable memory. The caller selects a chain by number: 0 for the common chain, 1 to 7 for one function's chain. The walker first fetches a 24-bit start pointer from three register bytes, least significant byte first. The bytes sit at offsets 9, 10 and 11 of the 256-byte register page of the selected number. It then follows the chain through a synchronous read port with one cycle of latency.

Each tuple is a code byte, a link byte and a body whose length is the link value. The walker reports every tuple with a one-cycle strobe that carries its code, link and start address. If asked, it also streams the body bytes in address order. It skips null records, stops cleanly at the end marker, and ends with an error code when a pointer or link leaves the memory window or when too many tuples appear. As an option it latches the start address of the first tuple whose code equals a requested value.

Top module: `tpl_chain_walker`

## Requirements
- R1: After a start, the first three reads go to addresses F*256+9, F*256+10 and F*256+11, where F is func_sel. The pointer is assembled as byte0 | byte1<<8 | byte2<<16.
- R2: Every tuple found is reported, in chain order, by a one-cycle tuple_valid pulse carrying its code, its link and its start address.
- R3: The next tuple starts at current address + 2 + link.
- R4: A code byte of 0x00 is a null record. It is not reported, and the walk continues at the next byte.
- R5: A code byte of 0xFF ends the walk with a done pulse and is not reported. A pointer that leads straight to 0xFF gives done with zero tuples reported.
- R6: When body_en is high at start, each body byte of a reported tuple appears on a body_valid pulse after that tuple's tuple_valid. The bytes come in address order, and body_idx counts from 0. With body_en low, or a link of 0, no body bytes appear.
- R7: A tuple with link 0xFF is reported and then ends the walk with done, with no further code read.
- R8: If address + 1 + link exceeds the last window address (2^ADDR_W - 1), the tuple is not reported and the walk ends with error, err_code = 2.
- R9: If the start pointer, or any code address reached, exceeds the last window address, the walk ends with error, err_code = 1. No read is ever issued outside the window.
- R10: Once MAX_TUPLES tuples have been reported, a further code that is neither null nor 0xFF ends the walk with error, err_code = 3. A chain of exactly MAX_TUPLES tuples ends with done.
- R11: With match_en high at start, the first tuple whose code equals match_code sets match_hit and latches its start address in match_addr. A later equal tuple does not change it. Both are cleared at the next start.
- R12: busy rises the cycle after an accepted start and falls in the cycle done or error pulses. done and error never pulse together. A start while busy is ignored. err_code is 0 after done and holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk when idle |
| func_sel | input | 3 | Chain number: 0 common, 1 to 7 function |
| body_en | input | 1 | Stream body bytes during this walk |
| match_en | input | 1 | Enable code match during this walk |
| match_code | input | 8 | Code to match |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: chain ended normally |
| error | output | 1 | One-cycle pulse: walk aborted |
| err_code | output | 2 | 0 none, 1 range, 2 link overrun, 3 count limit |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |
| tuple_valid | output | 1 | One-cycle tuple report strobe |
| tuple_code | output | 8 | Reported tuple code |
| tuple_link | output | 8 | Reported tuple link |
| tuple_addr | output | ADDR_W | Reported tuple start address |
| body_valid | output | 1 | Body byte strobe |
| body_data | output | 8 | Body byte |
| body_idx | output | 8 | Index of the body byte within its tuple |
| match_hit | output | 1 | A matching tuple was found |
| match_addr | output | ADDR_W | Start address of the first match |

## Verification
The bench runs a mixed chain that interleaves a null record with two tuples of different link lengths, once with body streaming and once without. This separates address stepping and null skipping from body delivery. A pointer whose three bytes all differ is used to expose any wrong byte order. A pointer straight to the end marker covers the zero-tuple case. Tuples placed at the top of the window with link values one apart separate a legal end from an overrun and from a range error on the next code. A maximal-link tuple, and chains of exactly the tuple limit and one more, cover the early stop and the count watchdog.

// File: rtl/tcw_pkg.sv
`timescale 1ns/1ps
package tcw_pkg;
  localparam int FUNC_W    = 3;
  localparam int PTR_BYTES = 3;
  localparam int PTR_W     = 8 * PTR_BYTES;
  localparam int CUR_W     = PTR_W + 1;

  localparam logic [7:0] CODE_END  = 8'hFF;
  localparam logic [7:0] CODE_NULL = 8'h00;
  localparam logic [7:0] LINK_MAX  = 8'hFF;

  typedef enum logic [1:0] {
    TCW_ERR_NONE  = 2'd0,
    TCW_ERR_RANGE = 2'd1,
    TCW_ERR_LINK  = 2'd2,
    TCW_ERR_COUNT = 2'd3
  } tcw_err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PTR_RD, S_PTR_CAP, S_PTR_SET,
    S_CODE_RD, S_CODE_CAP, S_LINK_RD, S_LINK_CAP,
    S_BODY_RD, S_BODY_CAP
  } tcw_state_e;

  // Address of the first pointer byte for a chain number
  function automatic logic [CUR_W-1:0] tcw_ptr_reg_addr(input logic [FUNC_W-1:0] f,
                                                        input logic [7:0] ofs);
    return (CUR_W'(f) << 8) + CUR_W'(ofs);
  endfunction

  // Address of the last byte covered by a tuple
  function automatic logic [CUR_W-1:0] tcw_last_byte(input logic [CUR_W-1:0] a,
                                                     input logic [7:0] link);
    return a + CUR_W'(1) + CUR_W'(link);
  endfunction

  // Start of the following tuple
  function automatic logic [CUR_W-1:0] tcw_next_addr(input logic [CUR_W-1:0] a,
                                                     input logic [7:0] link);
    return a + CUR_W'(2) + CUR_W'(link);
  endfunction
endpackage

// File: rtl/tcw_ptr_asm.sv
`timescale 1ns/1ps
module tcw_ptr_asm #(
  parameter int NBYTES = 3,
  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  load,
  input  logic [IDX_W-1:0]      idx,
  input  logic [7:0]            byte_in,
  output logic [8*NBYTES-1:0]   ptr
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr)                        slot_q <= '0;
      else if (load && idx == IDX_W'(g))        slot_q <= byte_in;
    end
    assign ptr[8*g +: 8] = slot_q;
  end

  AST_PTR_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (32'(idx) < NBYTES)); // R1
endmodule

// File: rtl/tcw_tuple_ctr.sv
`timescale 1ns/1ps
module tcw_tuple_ctr #(
  parameter int MAX = 256,
  localparam int CNT_W = $clog2(MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  cnt_q <= '0;
    else if (inc)       cnt_q <= cnt_q + CNT_W'(1);
  end

  assign at_limit = (cnt_q == CNT_W'(MAX));

  AST_CNT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) <= MAX); // R10
  AST_NO_INC_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> !at_limit); // R10
endmodule

// File: rtl/tcw_match_latch.sv
`timescale 1ns/1ps
module tcw_match_latch #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en_in,
  input  logic [7:0]    code_in,
  input  logic          tup_fire,
  input  logic [7:0]    tup_code,
  input  logic [AW-1:0] tup_addr,
  output logic          hit,
  output logic [AW-1:0] addr
);
  logic       en_q;
  logic [7:0] code_q;
  logic       take;

  assign take = tup_fire && en_q && !hit && (tup_code == code_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; code_q <= '0; hit <= 1'b0; addr <= '0;
    end else if (clr) begin
      en_q <= en_in; code_q <= code_in; hit <= 1'b0; addr <= '0;
    end else if (take) begin
      hit <= 1'b1; addr <= tup_addr;
    end
  end

  AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |=> (hit && $stable(addr))); // R11
endmodule

// File: rtl/tpl_chain_walker.sv
`timescale 1ns/1ps
module tpl_chain_walker
  import tcw_pkg::*;
#(
  parameter int         ADDR_W     = 17,
  parameter int         MAX_TUPLES = 256,
  parameter logic [7:0] PTR_OFS    = 8'h09
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        func_sel,
  input  logic              body_en,
  input  logic              match_en,
  input  logic [7:0]        match_code,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [1:0]        err_code,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              tuple_valid,
  output logic [7:0]        tuple_code,
  output logic [7:0]        tuple_link,
  output logic [ADDR_W-1:0] tuple_addr,
  output logic              body_valid,
  output logic [7:0]        body_data,
  output logic [7:0]        body_idx,
  output logic              match_hit,
  output logic [ADDR_W-1:0] match_addr
);
  localparam logic [CUR_W-1:0] WIN_LAST = CUR_W'((64'd1 << ADDR_W) - 64'd1);
  localparam int IDX_W = $clog2(PTR_BYTES);

  tcw_state_e        state_q;
  logic [IDX_W-1:0]  k_q;
  logic [CUR_W-1:0]  cur_q;
  logic [7:0]        code_q, link_q, bi_q;
  logic [FUNC_W-1:0] func_q;
  logic              body_q;
  tcw_err_e          err_q;

  logic [PTR_W-1:0]  ptr_w;
  logic              at_limit;
  logic [CUR_W-1:0]  preg_addr, rd_full;

  // Named internal events
  logic ev_launch, ev_code_range, ev_link_range, ev_link_bad, ev_tuple_fire;

  assign preg_addr     = tcw_ptr_reg_addr(func_q, PTR_OFS);
  assign ev_launch     = (state_q == S_IDLE) && start;
  assign ev_code_range = (state_q == S_CODE_RD) && (cur_q > WIN_LAST);
  assign ev_link_range = (state_q == S_LINK_RD) && ((cur_q + CUR_W'(1)) > WIN_LAST);
  assign ev_link_bad   = (state_q == S_LINK_CAP) && (tcw_last_byte(cur_q, mem_rdata) > WIN_LAST);
  assign ev_tuple_fire = (state_q == S_LINK_CAP) && !ev_link_bad;

  tcw_ptr_asm #(.NBYTES(PTR_BYTES)) ptr_i (
    .clk(clk), .rst_n(rst_n), .clr(ev_launch),
    .load(state_q == S_PTR_CAP), .idx(k_q), .byte_in(mem_rdata), .ptr(ptr_w)
  );

  tcw_tuple_ctr #(.MAX(MAX_TUPLES)) ctr_i (
    .clk(clk), .rst_n(rst_n), .clr(ev_launch), .inc(ev_tuple_fire), .at_limit(at_limit)
  );

  tcw_match_latch #(.AW(ADDR_W)) match_i (
    .clk(clk), .rst_n(rst_n), .clr(ev_launch), .en_in(match_en), .code_in(match_code),
    .tup_fire(ev_tuple_fire), .tup_code(code_q), .tup_addr(cur_q[ADDR_W-1:0]),
    .hit(match_hit), .addr(match_addr)
  );

  // Read port
  always_comb begin
    mem_rd_en = 1'b0;
    rd_full   = '0;
    case (state_q)
      S_PTR_RD:  begin mem_rd_en = 1'b1;           rd_full = preg_addr + CUR_W'(k_q); end
      S_CODE_RD: begin mem_rd_en = !ev_code_range; rd_full = cur_q; end
      S_LINK_RD: begin mem_rd_en = !ev_link_range; rd_full = cur_q + CUR_W'(1); end
      S_BODY_RD: begin mem_rd_en = 1'b1;           rd_full = cur_q + CUR_W'(2) + CUR_W'(bi_q); end
      default: ;
    endcase
  end
  assign mem_addr = rd_full[ADDR_W-1:0];

  assign busy     = (state_q != S_IDLE);
  assign err_code = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE; k_q <= '0; cur_q <= '0; code_q <= '0; link_q <= '0;
      bi_q <= '0; func_q <= '0; body_q <= 1'b0; err_q <= TCW_ERR_NONE;
      done <= 1'b0; error <= 1'b0; tuple_valid <= 1'b0; tuple_code <= '0;
      tuple_link <= '0; tuple_addr <= '0; body_valid <= 1'b0; body_data <= '0;
      body_idx <= '0;
    end else begin
      done        <= 1'b0;
      error       <= 1'b0;
      tuple_valid <= 1'b0;
      body_valid  <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          func_q  <= func_sel;
          body_q  <= body_en;
          k_q     <= '0;
          err_q   <= TCW_ERR_NONE;
          state_q <= S_PTR_RD;
        end
        S_PTR_RD:  state_q <= S_PTR_CAP;
        S_PTR_CAP: begin
          if (32'(k_q) == PTR_BYTES - 1) state_q <= S_PTR_SET;
          else begin
            k_q     <= k_q + IDX_W'(1);
            state_q <= S_PTR_RD;
          end
        end
        S_PTR_SET: begin
          cur_q   <= CUR_W'(ptr_w);
          state_q <= S_CODE_RD;
        end
        S_CODE_RD: begin
          if (ev_code_range) begin
            err_q <= TCW_ERR_RANGE; error <= 1'b1; state_q <= S_IDLE;
          end else state_q <= S_CODE_CAP;
        end
        S_CODE_CAP: begin
          code_q <= mem_rdata;
          if (mem_rdata == CODE_END) begin
            done <= 1'b1; state_q <= S_IDLE;
          end else if (mem_rdata == CODE_NULL) begin
            cur_q   <= cur_q + CUR_W'(1);
            state_q <= S_CODE_RD;
          end else if (at_limit) begin
            err_q <= TCW_ERR_COUNT; error <= 1'b1; state_q <= S_IDLE;
          end else state_q <= S_LINK_RD;
        end
        S_LINK_RD: begin
          if (ev_link_range) begin
            err_q <= TCW_ERR_LINK; error <= 1'b1; state_q <= S_IDLE;
          end else state_q <= S_LINK_CAP;
        end
        S_LINK_CAP: begin
          link_q <= mem_rdata;
          if (ev_link_bad) begin
            err_q <= TCW_ERR_LINK; error <= 1'b1; state_q <= S_IDLE;
          end else begin
            tuple_valid <= 1'b1;
            tuple_code  <= code_q;
            tuple_link  <= mem_rdata;
            tuple_addr  <= cur_q[ADDR_W-1:0];
            if (body_q && mem_rdata != 8'd0) begin
              bi_q    <= '0;
              state_q <= S_BODY_RD;
            end else begin
              cur_q <= tcw_next_addr(cur_q, mem_rdata);
              if (mem_rdata == LINK_MAX) begin
                done <= 1'b1; state_q <= S_IDLE;
              end else state_q <= S_CODE_RD;
            end
          end
        end
        S_BODY_RD: state_q <= S_BODY_CAP;
        S_BODY_CAP: begin
          body_valid <= 1'b1;
          body_data  <= mem_rdata;
          body_idx   <= bi_q;
          if (bi_q == link_q - 8'd1) begin
            cur_q <= tcw_next_addr(cur_q, link_q);
            if (link_q == LINK_MAX) begin
              done <= 1'b1; state_q <= S_IDLE;
            end else state_q <= S_CODE_RD;
          end else begin
            bi_q    <= bi_q + 8'd1;
            state_q <= S_BODY_RD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R12
  AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> !busy); // R12
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R12
  AST_NO_NULL_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    tuple_valid |-> (tuple_code != CODE_NULL)); // R4
  AST_NO_END_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    tuple_valid |-> (tuple_code != CODE_END)); // R5
  AST_BODY_WHEN_ASKED: assert property (@(posedge clk) disable iff (!rst_n)
    body_valid |-> body_q); // R6
  AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (err_code != 2'd0)); // R8
  AST_RD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (rd_full <= WIN_LAST)); // R9
endmodule

// File: tb/tpl_chain_walker_tb_top.sv
`timescale 1ns/1ps
module tpl_chain_walker_tb_top;
  localparam int AW = 12;
  localparam int MEM_N = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] func_sel = '0;
  logic body_en = 1'b0, match_en = 1'b0;
  logic [7:0] match_code = '0;
  logic busy, done, error, mem_rd_en, tuple_valid, body_valid, match_hit;
  logic [1:0] err_code;
  logic [AW-1:0] mem_addr, tuple_addr, match_addr;
  logic [7:0] mem_rdata, tuple_code, tuple_link, body_data, body_idx;

  always #2.5 clk = ~clk;

  tpl_chain_walker #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .func_sel(func_sel), .body_en(body_en),
    .match_en(match_en), .match_code(match_code), .busy(busy), .done(done),
    .error(error), .err_code(err_code), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .tuple_valid(tuple_valid), .tuple_code(tuple_code),
    .tuple_link(tuple_link), .tuple_addr(tuple_addr), .body_valid(body_valid),
    .body_data(body_data), .body_idx(body_idx), .match_hit(match_hit),
    .match_addr(match_addr)
  );

  logic [7:0] mem [0:MEM_N-1];
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

  int n_chk = 0, n_err = 0;
  int n_tv, n_bd, n_rd, n_done, n_errp;
  logic [7:0]    tv_code [0:299];
  logic [7:0]    tv_link [0:299];
  logic [AW-1:0] tv_addr [0:299];
  logic [7:0]    bd_data [0:299];
  logic [7:0]    bd_idx  [0:299];
  logic [AW-1:0] rd_log  [0:2047];

  always @(negedge clk) if (rst_n) begin
    if (tuple_valid) begin
      if (n_tv < 300) begin
        tv_code[n_tv] = tuple_code; tv_link[n_tv] = tuple_link; tv_addr[n_tv] = tuple_addr;
      end
      n_tv++;
    end
    if (body_valid) begin
      if (n_bd < 300) begin bd_data[n_bd] = body_data; bd_idx[n_bd] = body_idx; end
      n_bd++;
    end
    if (mem_rd_en) begin
      if (n_rd < 2048) rd_log[n_rd] = mem_addr;
      n_rd++;
    end
    if (done)  n_done++;
    if (error) n_errp++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'hFF;
  endtask

  task automatic put_ptr(input int f, input logic [23:0] p);
    mem[f*256 + 9]  = p[7:0];
    mem[f*256 + 10] = p[15:8];
    mem[f*256 + 11] = p[23:16];
  endtask

  task automatic put_tuple(input int a, input logic [7:0] c, input logic [7:0] l,
                           input logic [7:0] seed);
    mem[a] = c;
    mem[a+1] = l;
    for (int i = 0; i < int'(l); i++) mem[a+2+i] = seed + 8'(i);
  endtask

  task automatic run_walk(input logic [2:0] f, input logic be, input logic me,
                          input logic [7:0] mc);
    int cyc;
    n_tv = 0; n_bd = 0; n_rd = 0; n_done = 0; n_errp = 0;
    @(negedge clk);
    start = 1'b1; func_sel = f; body_en = be; match_en = me; match_code = mc;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!(done || error) && cyc < 6000) begin @(negedge clk); cyc++; end
    if (cyc >= 6000) begin
      n_chk++; n_err++;
      $display("FAIL R12 walk did not finish actual=busy expected=finish");
    end
    @(negedge clk);
  endtask

  task automatic mixed_chain();
    clear_mem();
    put_ptr(0, 24'h000120);
    put_tuple(12'h120, 8'h21, 8'd2, 8'hA0);
    mem[12'h124] = 8'h00;
    put_tuple(12'h125, 8'h15, 8'd3, 8'hB0);
  endtask

  task automatic t_reset();
    chk("R12 reset busy", 32'(busy), 0);
    chk("R12 reset done", 32'(done), 0);
    chk("R12 reset error", 32'(error), 0);
    chk("R2 reset tuple_valid", 32'(tuple_valid), 0);
    chk("R11 reset match_hit", 32'(match_hit), 0);
  endtask

  task automatic t_mixed_body();
    mixed_chain();
    run_walk(3'd0, 1'b1, 1'b1, 8'h15);
    chk("R1 read0", 32'(rd_log[0]), 32'h009);
    chk("R1 read1", 32'(rd_log[1]), 32'h00A);
    chk("R1 read2", 32'(rd_log[2]), 32'h00B);
    chk("R2 tuple count", n_tv, 2);
    chk("R2 t0 code", 32'(tv_code[0]), 32'h21);
    chk("R2 t0 link", 32'(tv_link[0]), 2);
    chk("R2 t0 addr", 32'(tv_addr[0]), 32'h120);
    chk("R4 t1 code after null", 32'(tv_code[1]), 32'h15);
    chk("R3 t1 addr", 32'(tv_addr[1]), 32'h125);
    chk("R6 body count", n_bd, 5);
    chk("R6 body0", 32'(bd_data[0]), 32'hA0);
    chk("R6 body1", 32'(bd_data[1]), 32'hA1);
    chk("R6 body1 idx", 32'(bd_idx[1]), 1);
    chk("R6 body4", 32'(bd_data[4]), 32'hB2);
    chk("R6 body4 idx", 32'(bd_idx[4]), 2);
    chk("R11 hit", 32'(match_hit), 1);
    chk("R11 addr", 32'(match_addr), 32'h125);
    chk("R5 done", n_done, 1);
    chk("R12 err code", 32'(err_code), 0);
  endtask

  task automatic t_mixed_nobody();
    mixed_chain();
    run_walk(3'd0, 1'b0, 1'b1, 8'h77);
    chk("R6 no body", n_bd, 0);
    chk("R3 tuple count", n_tv, 2);
    chk("R3 t1 addr", 32'(tv_addr[1]), 32'h125);
    chk("R11 no hit", 32'(match_hit), 0);
  endtask

  task automatic t_ptr_order();
    clear_mem();
    put_ptr(2, 24'h000A37);
    put_tuple(12'hA37, 8'h42, 8'd0, 8'h00);
    run_walk(3'd2, 1'b1, 1'b0, 8'h00);
    chk("R1 read0 func2", 32'(rd_log[0]), 32'h209);
    chk("R1 read2 func2", 32'(rd_log[2]), 32'h20B);
    chk("R1 tuple addr", 32'(tv_addr[0]), 32'hA37);
    chk("R6 link0 no body", n_bd, 0);
    chk("R1 done", n_done, 1);
  endtask

  task automatic t_empty();
    clear_mem();
    put_ptr(5, 24'h000300);
    run_walk(3'd5, 1'b0, 1'b0, 8'h00);
    chk("R5 zero tuples", n_tv, 0);
    chk("R5 done", n_done, 1);
    chk("R5 no error", n_errp, 0);
  endtask

  task automatic t_maxlink();
    clear_mem();
    put_ptr(0, 24'h000400);
    put_tuple(12'h400, 8'h33, 8'hFF, 8'h00);
    put_tuple(12'h501, 8'h30, 8'd0, 8'h00);
    run_walk(3'd0, 1'b1, 1'b0, 8'h00);
    chk("R7 one tuple", n_tv, 1);
    chk("R7 link", 32'(tv_link[0]), 32'hFF);
    chk("R7 body count", n_bd, 255);
    chk("R7 last body", 32'(bd_data[254]), 32'hFE);
    chk("R7 last idx", 32'(bd_idx[254]), 254);
    chk("R7 done", n_done, 1);
    chk("R7 no error", n_errp, 0);
  endtask

  task automatic t_edge_fit();
    clear_mem();
    put_ptr(1, 24'h000FF0);
    put_tuple(12'hFF0, 8'h21, 8'h0E, 8'h10);
    run_walk(3'd1, 1'b0, 1'b0, 8'h00);
    chk("R8 fitting tuple reported", n_tv, 1);
    chk("R9 next code out of window", n_errp, 1);
    chk("R9 err code", 32'(err_code), 1);
  endtask

  task automatic t_overrun();
    clear_mem();
    put_ptr(3, 24'h000FF0);
    mem[12'hFF0] = 8'h21;
    mem[12'hFF1] = 8'h0F;
    run_walk(3'd3, 1'b0, 1'b0, 8'h00);
    chk("R8 not reported", n_tv, 0);
    chk("R8 error", n_errp, 1);
    chk("R8 err code", 32'(err_code), 2);
  endtask

  task automatic t_bad_ptr();
    clear_mem();
    put_ptr(4, 24'h001000);
    run_walk(3'd4, 1'b0, 1'b0, 8'h00);
    chk("R9 only pointer reads", n_rd, 3);
    chk("R9 err code", 32'(err_code), 1);
    chk("R9 no done", n_done, 0);
  endtask

  task automatic t_limit(input int ntup);
    clear_mem();
    put_ptr(0, 24'h000800);
    for (int i = 0; i < ntup; i++) put_tuple(12'h800 + 2*i, 8'h20, 8'd0, 8'h00);
    run_walk(3'd0, 1'b0, 1'b1, 8'h20);
    chk("R11 first match addr", 32'(match_addr), 32'h800);
    if (ntup > 256) begin
      chk("R10 tuples before limit", n_tv, 256);
      chk("R10 err code", 32'(err_code), 3);
    end else begin
      chk("R10 full chain", n_tv, ntup);
      chk("R10 done at limit", n_done, 1);
    end
  endtask

  task automatic t_busy_start();
    int cyc;
    mixed_chain();
    n_tv = 0; n_bd = 0; n_rd = 0; n_done = 0; n_errp = 0;
    @(negedge clk);
    start = 1'b1; func_sel = 3'd0; body_en = 1'b0; match_en = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk("R12 busy after start", 32'(busy), 1);
    repeat (5) @(negedge clk);
    start = 1'b1; func_sel = 3'd5;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (cyc < 80) begin @(negedge clk); cyc++; end
    chk("R12 ignored start tuples", n_tv, 2);
    chk("R12 single done", n_done, 1);
    chk("R12 idle after", 32'(busy), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mixed_body();
    t_mixed_nobody();
    t_ptr_order();
    t_empty();
    t_maxlink();
    t_edge_fit();
    t_overrun();
    t_bad_ptr();
    t_limit(257);
    t_limit(256);
    t_busy_start();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule